// File: doc/BRIEF.md
# Mode-Controlled Registered Bus Transceiver

This block carries an 18-bit data word in either direction between two ports, A and B. The data path can run in one of three ways. It can pass data straight through, hold a word it has captured, or load a new word on a clock edge. The block also forwards clocks for two kinds of transfer. In source-synchronous transfer, the bus clock travels with the data. In clock-synchronous transfer, both sides capture on the local system clock. Tristate pins appear as value and enable pairs. Level translation is done outside the block.

Every control, clock and data input is sampled in a fast reference clock through `SYNC_DEPTH` register stages. Clock edges are found by comparing two consecutive samples, so the reference clock must run at least four times faster than the data clocks. The pass control has two jobs. When high, it selects straight-through data and turns off both clock outputs. When low, it selects stored data and forwards the clocks. The sync-select input decides which clock the receive side uses for capture.

Top module: `bus_xcvr`

## Requirements
- R1: When `den_ni` is 1, `a_oe_o` and `b_oe_o` are both 0.
- R2: When `pass_i` is 1 and `den_ni` is 0, the data path is non-inverting. With `dir_i`=0 (A to B), `b_o` equals `a_i` and `b_oe_o` is 1. With `dir_i`=1 (B to A), `a_o` equals `b_i` and `a_oe_o` is 1.
- R3: When `pass_i` is 1, `bclk_oe_o` and `lclk_oe_o` are both 0, whatever the value of `den_ni`.
- R4: When `dir_i`=0 and `pass_i`=0, the A-to-B register loads `a_i` on a rising edge of `sysclk_i` and `b_o` shows that register. Between edges, `b_o` holds its value even if `a_i` changes. In this mode `bclk_o` and `lclk_o` follow `sysclk_i`, and both of their enables are 1.
- R5: A falling edge of `pass_i` captures the current input word into the register of the selected direction. The output then keeps that word.
- R6: When `dir_i`=1, `pass_i`=0 and `csync_i`=0 (source-synchronous), `bclk_oe_o` is 0. The B-to-A register loads `b_i` on a rising edge of `bclk_i`, and `sysclk_i` edges do not load it. `lclk_o` follows `bclk_i`.
- R7: When `dir_i`=1, `pass_i`=0 and `csync_i`=1 (clock-synchronous), `bclk_oe_o` is 1 and `bclk_o` follows `sysclk_i`. The B-to-A register loads on a rising edge of `sysclk_i`, and `bclk_i` edges do not load it. `lclk_o` follows `sysclk_i`.
- R8: With `den_ni`=1 and `pass_i`=0 (isolation), the registers still load on their active edges and both clock outputs stay enabled. When `den_ni` later goes to 0, the stored word is driven.
- R9: With `dir_i`=0, `csync_i` has no effect: the bus clock output is always enabled and driven from `sysclk_i`.
- R10: After reset, both registers are zero and every enable is 0 until the sampled inputs are valid.
- R11: `a_oe_o` and `b_oe_o` are never 1 together. After a change of `dir_i`, the new port's enable rises at least one reference cycle after the old port's enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock that samples every input |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Transfer direction: 0 = A to B, 1 = B to A |
| den_ni | input | 1 | Active-low enable for the data outputs |
| pass_i | input | 1 | 1 = pass data straight through, clocks off; 0 = stored data, clocks forwarded |
| csync_i | input | 1 | Receive capture clock: 0 = bus clock, 1 = system clock |
| sysclk_i | input | 1 | System clock level |
| bclk_i | input | 1 | Bus clock pin, read when the block is not driving it |
| a_i | input | WIDTH | Value read from port A |
| b_i | input | WIDTH | Value read from port B |
| a_o | output | WIDTH | Value driven onto port A |
| a_oe_o | output | 1 | Drive enable for port A |
| b_o | output | WIDTH | Value driven onto port B |
| b_oe_o | output | 1 | Drive enable for port B |
| bclk_o | output | 1 | Value driven onto the bus clock pin |
| bclk_oe_o | output | 1 | Drive enable for the bus clock pin |
| lclk_o | output | 1 | Local clock output |
| lclk_oe_o | output | 1 | Drive enable for the local clock |

## Verification
A register that loads on the wrong clock shows up one reference cycle after the edge the sampler detects. The driven port then holds a word that differs from the last one presented before the intended edge. This is checked after edges of both bus clock and system clock, to see that only the selected clock moves the data. A missing capture on the pass fall leaves the reset or previous word on the output as soon as stored mode begins. A broken handover shows up in the very first cycles after a direction change, as both port enables high together or as no idle cycle between them.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

   typedef enum logic {
      DIR_A2B = 1'b0,
      DIR_B2A = 1'b1
   } xc_dir_e;

   typedef struct packed {
      logic dir;
      logic den_n;
      logic pass;
      logic csync;
      logic sysclk;
      logic bclk;
   } xc_ctrl_t;

   // Reset image of the sampled controls: data drive off, pass low so that
   // the first valid sample cannot look like a falling pass edge.
   parameter xc_ctrl_t CTRL_RST = '{dir: 1'b0, den_n: 1'b1, pass: 1'b0,
                                    csync: 1'b0, sysclk: 1'b0, bclk: 1'b0};

endpackage

// File: rtl/bus_xcvr_sampler.sv
module bus_xcvr_sampler
   import bus_xcvr_pkg::*;
#(
   parameter int WIDTH      = 18,
   parameter int SYNC_DEPTH = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  xc_ctrl_t         ctrl_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             vld_o,
   output xc_ctrl_t         ctrl_s_o,
   output logic [WIDTH-1:0] a_s_o,
   output logic [WIDTH-1:0] b_s_o,
   output logic             sys_rise_o,
   output logic             bus_rise_o,
   output logic             pass_fall_o
);

   localparam int CW = $bits(xc_ctrl_t);
   localparam int SW = 1 + CW + 2 * WIDTH;
   localparam logic [SW-1:0] RST_WORD = {1'b0, CTRL_RST, {(2 * WIDTH){1'b0}}};

   if (SYNC_DEPTH < 1 || SYNC_DEPTH > 4) begin : g_bad_depth
      $error("bus_xcvr_sampler: SYNC_DEPTH must lie in 1..4");
   end

   logic [SW-1:0] in_word;
   logic [SW-1:0] stg_q [SYNC_DEPTH];
   logic [2:0]    prev_q;   // {pass, sysclk, bclk} one sample older

   assign in_word = {1'b1, ctrl_i, a_i, b_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < SYNC_DEPTH; i++) stg_q[i] <= RST_WORD;
         prev_q <= {CTRL_RST.pass, CTRL_RST.sysclk, CTRL_RST.bclk};
      end else begin
         stg_q[0] <= in_word;
         for (int i = 1; i < SYNC_DEPTH; i++) stg_q[i] <= stg_q[i-1];
         prev_q <= {ctrl_s_o.pass, ctrl_s_o.sysclk, ctrl_s_o.bclk};
      end
   end

   assign {vld_o, ctrl_s_o, a_s_o, b_s_o} = stg_q[SYNC_DEPTH-1];

   assign pass_fall_o = prev_q[2] & ~ctrl_s_o.pass;
   assign sys_rise_o  = ~prev_q[1] & ctrl_s_o.sysclk;
   assign bus_rise_o  = ~prev_q[0] & ctrl_s_o.bclk;

endmodule

// File: rtl/bus_xcvr_store.sv
module bus_xcvr_store #(
   parameter int WIDTH = 18
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("bus_xcvr_store: WIDTH must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= '0;
      else if (load_i) q_o <= d_i;
   end

endmodule

// File: rtl/bus_xcvr_drive.sv
module bus_xcvr_drive (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic want_a_i,
   input  logic want_b_i,
   output logic en_a_o,
   output logic en_b_o
);

   // A port may turn on only in a cycle where the other port was off
   // in the previous cycle, which leaves one idle cycle on every handover.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_a_o <= 1'b0;
         en_b_o <= 1'b0;
      end else begin
         en_a_o <= want_a_i & ~en_b_o;
         en_b_o <= want_b_i & ~en_a_o;
      end
   end

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
   import bus_xcvr_pkg::*;
#(
   parameter int WIDTH      = 18,
   parameter int SYNC_DEPTH = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             dir_i,
   input  logic             den_ni,
   input  logic             pass_i,
   input  logic             csync_i,
   input  logic             sysclk_i,
   input  logic             bclk_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] a_o,
   output logic             a_oe_o,
   output logic [WIDTH-1:0] b_o,
   output logic             b_oe_o,
   output logic             bclk_o,
   output logic             bclk_oe_o,
   output logic             lclk_o,
   output logic             lclk_oe_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("bus_xcvr: WIDTH must be at least 1");
   end

   xc_ctrl_t         ctrl_in;
   xc_ctrl_t         ctrl_s;
   logic             vld;
   logic [WIDTH-1:0] a_s;
   logic [WIDTH-1:0] b_s;
   logic             sys_rise;
   logic             bus_rise;
   logic             pass_fall;
   logic             is_rx;
   logic             rx_edge;
   logic             load_ab;
   logic             load_ba;
   logic [WIDTH-1:0] q_ab;
   logic [WIDTH-1:0] q_ba;
   logic             clk_on;

   assign ctrl_in = '{dir: dir_i, den_n: den_ni, pass: pass_i,
                      csync: csync_i, sysclk: sysclk_i, bclk: bclk_i};

   bus_xcvr_sampler #(
      .WIDTH      (WIDTH),
      .SYNC_DEPTH (SYNC_DEPTH)
   ) u_sampler (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctrl_i      (ctrl_in),
      .a_i         (a_i),
      .b_i         (b_i),
      .vld_o       (vld),
      .ctrl_s_o    (ctrl_s),
      .a_s_o       (a_s),
      .b_s_o       (b_s),
      .sys_rise_o  (sys_rise),
      .bus_rise_o  (bus_rise),
      .pass_fall_o (pass_fall)
   );

   assign is_rx   = (ctrl_s.dir == DIR_B2A);
   // Receive capture clock: bus clock for source-synchronous, system clock otherwise.
   assign rx_edge = ctrl_s.csync ? sys_rise : bus_rise;
   assign load_ab = vld & ~is_rx & (pass_fall | (~ctrl_s.pass & sys_rise));
   assign load_ba = vld &  is_rx & (pass_fall | (~ctrl_s.pass & rx_edge));

   bus_xcvr_store #(.WIDTH(WIDTH)) u_store_ab (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_ab),
      .d_i    (a_s),
      .q_o    (q_ab)
   );

   bus_xcvr_store #(.WIDTH(WIDTH)) u_store_ba (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_ba),
      .d_i    (b_s),
      .q_o    (q_ba)
   );

   bus_xcvr_drive u_drive (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .want_a_i (vld & ~ctrl_s.den_n &  is_rx),
      .want_b_i (vld & ~ctrl_s.den_n & ~is_rx),
      .en_a_o   (a_oe_o),
      .en_b_o   (b_oe_o)
   );

   assign b_o = ctrl_s.pass ? a_s : q_ab;
   assign a_o = ctrl_s.pass ? b_s : q_ba;

   assign clk_on    = vld & ~ctrl_s.pass;
   assign bclk_oe_o = clk_on & (~is_rx | ctrl_s.csync);
   assign bclk_o    = ctrl_s.sysclk;
   assign lclk_oe_o = clk_on;
   assign lclk_o    = (is_rx & ~ctrl_s.csync) ? ctrl_s.bclk : ctrl_s.sysclk;

endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk
   import bus_xcvr_pkg::*;
#(
   parameter int WIDTH = 18
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             vld_i,
   input xc_ctrl_t         ctrl_i,
   input logic             sys_rise_i,
   input logic             bus_rise_i,
   input logic             pass_fall_i,
   input logic [WIDTH-1:0] a_s_i,
   input logic [WIDTH-1:0] b_s_i,
   input logic [WIDTH-1:0] a_o,
   input logic             a_oe_o,
   input logic [WIDTH-1:0] b_o,
   input logic             b_oe_o,
   input logic             bclk_oe_o,
   input logic             lclk_oe_o
);

   AST_RESET_IDLE: assert property (@(posedge clk_i)
      !rst_ni |=> !a_oe_o && !b_oe_o && !bclk_oe_o && !lclk_oe_o); // R10

   AST_DISABLE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_i.den_n |=> !a_oe_o && !b_oe_o); // R1

   AST_NO_DUAL_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(a_oe_o && b_oe_o)); // R11

   AST_GAP_B_TO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(b_oe_o) |-> !a_oe_o); // R11

   AST_GAP_A_TO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(a_oe_o) |-> !b_oe_o); // R11

   AST_TX_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && !ctrl_i.pass && ctrl_i.dir == DIR_A2B && sys_rise_i)
      ##1 (!ctrl_i.pass && ctrl_i.dir == DIR_A2B) |-> b_o == $past(a_s_i)); // R4

   AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && !ctrl_i.pass && ctrl_i.dir == DIR_A2B && !sys_rise_i && !pass_fall_i)
      ##1 (!ctrl_i.pass && ctrl_i.dir == DIR_A2B) |-> $stable(b_o)); // R4

   AST_RX_SRC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && !ctrl_i.pass && ctrl_i.dir == DIR_B2A && !ctrl_i.csync && bus_rise_i)
      ##1 (!ctrl_i.pass && ctrl_i.dir == DIR_B2A) |-> a_o == $past(b_s_i)); // R6

   AST_RX_SYNC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && !ctrl_i.pass && ctrl_i.dir == DIR_B2A && ctrl_i.csync && sys_rise_i)
      ##1 (!ctrl_i.pass && ctrl_i.dir == DIR_B2A) |-> a_o == $past(b_s_i)); // R7

endmodule

bind bus_xcvr bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .vld_i       (vld),
   .ctrl_i      (ctrl_s),
   .sys_rise_i  (sys_rise),
   .bus_rise_i  (bus_rise),
   .pass_fall_i (pass_fall),
   .a_s_i       (a_s),
   .b_s_i       (b_s),
   .a_o         (a_o),
   .a_oe_o      (a_oe_o),
   .b_o         (b_o),
   .b_oe_o      (b_oe_o),
   .bclk_oe_o   (bclk_oe_o),
   .lclk_oe_o   (lclk_oe_o)
);

// File: tb/bus_xcvr_bench.sv
`timescale 1ns/1ps
module bus_xcvr_bench;

   localparam int W      = 18;
   localparam int SETTLE = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         dir, den_n, pass, csync, sysclk, bclk;
   logic [W-1:0] a_in, b_in;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe, bclk_out, bclk_oe, lclk_out, lclk_oe;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   bus_xcvr #(.WIDTH(W), .SYNC_DEPTH(2)) u_bus_xcvr (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .dir_i     (dir),
      .den_ni    (den_n),
      .pass_i    (pass),
      .csync_i   (csync),
      .sysclk_i  (sysclk),
      .bclk_i    (bclk),
      .a_i       (a_in),
      .b_i       (b_in),
      .a_o       (a_out),
      .a_oe_o    (a_oe),
      .b_o       (b_out),
      .b_oe_o    (b_oe),
      .bclk_o    (bclk_out),
      .bclk_oe_o (bclk_oe),
      .lclk_o    (lclk_out),
      .lclk_oe_o (lclk_oe)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_sys();
      sysclk = 1'b1; step(SETTLE);
      sysclk = 1'b0; step(SETTLE);
   endtask

   task automatic pulse_bus();
      bclk = 1'b1; step(SETTLE);
      bclk = 1'b0; step(SETTLE);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; dir = 1'b0; den_n = 1'b0; pass = 1'b0; csync = 1'b0;
      sysclk = 1'b0; bclk = 1'b0; a_in = 18'h3FFFF; b_in = '0;
      step(3);
      chk("R10", "a_oe in reset", a_oe, 0);
      chk("R10", "b_oe in reset", b_oe, 0);
      chk("R10", "bclk_oe in reset", bclk_oe, 0);
      chk("R10", "lclk_oe in reset", lclk_oe, 0);
      rst_n = 1'b1;
      step(SETTLE);
      chk("R10", "b_out cleared register", b_out, 0);
      chk("R10", "b_oe after valid", b_oe, 1);
   endtask

   task automatic t_transparent_tx();
      pass = 1'b1; dir = 1'b0; a_in = 18'h2A5C3;
      step(SETTLE);
      chk("R2", "b_out pattern 1", b_out, 18'h2A5C3);
      chk("R2", "b_oe", b_oe, 1);
      chk("R2", "a_oe", a_oe, 0);
      chk("R3", "bclk_oe pass", bclk_oe, 0);
      chk("R3", "lclk_oe pass", lclk_oe, 0);
      a_in = 18'h15A3C;
      step(SETTLE);
      chk("R2", "b_out pattern 2", b_out, 18'h15A3C);
   endtask

   task automatic t_handover();
      int  both_on = 0;
      bit  gap     = 1'b0;
      bit  b_gone  = 1'b0;
      bit  a_seen  = 1'b0;
      b_in = 18'h0F0F0;
      dir  = 1'b1;
      for (int i = 0; i < 12; i++) begin
         step(1);
         if (a_oe && b_oe) both_on++;
         if (!b_oe) b_gone = 1'b1;
         if (b_gone && !a_seen && !a_oe && !b_oe) gap = 1'b1;
         if (a_oe) a_seen = 1'b1;
      end
      chk("R11", "cycles with both enables", both_on, 0);
      chk("R11", "idle cycle before new port", gap, 1);
      chk("R11", "a_oe on after handover", a_oe, 1);
      chk("R2", "a_out B to A", a_out, 18'h0F0F0);
   endtask

   task automatic t_all_off();
      den_n = 1'b1; pass = 1'b1;
      step(SETTLE);
      chk("R1", "a_oe disabled", a_oe, 0);
      chk("R1", "b_oe disabled", b_oe, 0);
      chk("R3", "bclk_oe disabled", bclk_oe, 0);
      chk("R3", "lclk_oe disabled", lclk_oe, 0);
      den_n = 1'b0;
   endtask

   task automatic t_tx_clocked();
      dir = 1'b0; pass = 1'b1; a_in = 18'h12345;
      step(SETTLE);
      pass = 1'b0;
      step(SETTLE);
      chk("R5", "b_out after pass fall", b_out, 18'h12345);
      a_in = 18'h2BCDE;
      step(SETTLE);
      chk("R4", "b_out held between edges", b_out, 18'h12345);
      chk("R4", "bclk_oe tx", bclk_oe, 1);
      chk("R4", "lclk_oe tx", lclk_oe, 1);
      sysclk = 1'b1;
      step(SETTLE);
      chk("R4", "b_out after sys rise", b_out, 18'h2BCDE);
      chk("R4", "bclk_out high", bclk_out, 1);
      chk("R4", "lclk_out high", lclk_out, 1);
      sysclk = 1'b0;
      step(SETTLE);
      chk("R4", "bclk_out low", bclk_out, 0);
      chk("R4", "lclk_out low", lclk_out, 0);
      csync = 1'b1; a_in = 18'h00FF0;
      pulse_sys();
      chk("R9", "b_out sys capture with csync", b_out, 18'h00FF0);
      chk("R9", "bclk_oe with csync", bclk_oe, 1);
      csync = 1'b0;
      step(SETTLE);
      chk("R9", "bclk_oe without csync", bclk_oe, 1);
   endtask

   task automatic t_rx_src();
      dir = 1'b1; pass = 1'b1; csync = 1'b0; b_in = 18'h3C3C3;
      step(SETTLE);
      pass = 1'b0;
      step(SETTLE);
      chk("R5", "a_out after pass fall", a_out, 18'h3C3C3);
      chk("R6", "bclk_oe src sync", bclk_oe, 0);
      chk("R6", "lclk_oe src sync", lclk_oe, 1);
      b_in = 18'h05A5A;
      pulse_sys();
      chk("R6", "a_out ignores sys edge", a_out, 18'h3C3C3);
      bclk = 1'b1;
      step(SETTLE);
      chk("R6", "a_out after bus rise", a_out, 18'h05A5A);
      chk("R6", "lclk_out follows bus high", lclk_out, 1);
      bclk = 1'b0;
      step(SETTLE);
      chk("R6", "lclk_out follows bus low", lclk_out, 0);
   endtask

   task automatic t_rx_clk();
      csync = 1'b1;
      step(SETTLE);
      chk("R7", "bclk_oe clk sync", bclk_oe, 1);
      b_in = 18'h2DB6D;
      pulse_bus();
      chk("R7", "a_out ignores bus edge", a_out, 18'h05A5A);
      sysclk = 1'b1;
      step(SETTLE);
      chk("R7", "a_out after sys rise", a_out, 18'h2DB6D);
      chk("R7", "bclk_out follows sys", bclk_out, 1);
      chk("R7", "lclk_out follows sys", lclk_out, 1);
      sysclk = 1'b0;
      step(SETTLE);
      chk("R7", "lclk_out sys low", lclk_out, 0);
      csync = 1'b0;
   endtask

   task automatic t_isolation();
      den_n = 1'b1; dir = 1'b0;
      step(SETTLE);
      a_in = 18'h33333;
      pulse_sys();
      chk("R8", "b_oe isolated", b_oe, 0);
      chk("R8", "a_oe isolated", a_oe, 0);
      chk("R8", "lclk_oe isolated", lclk_oe, 1);
      chk("R8", "bclk_oe isolated", bclk_oe, 1);
      den_n = 1'b0;
      step(SETTLE);
      chk("R8", "b_out stored in isolation", b_out, 18'h33333);
      chk("R8", "b_oe after enable", b_oe, 1);
   endtask

   initial begin
      t_reset();
      t_transparent_tx();
      t_handover();
      t_all_off();
      t_tx_clocked();
      t_rx_src();
      t_rx_clk();
      t_isolation();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule